// File: doc/BRIEF.md
# Complementary PWM Output Stage

This block sits between a PWM channel counter and a pair of output pins, an even pin and an odd pin. It takes one raw PWM waveform and a flag that says whether the counter is running. From these it makes the two pin levels. In independent mode both pins follow the raw waveform directly. In complementary mode the odd pin is driven from the inverse of the raw waveform. Each pin's turn-on is then delayed by a programmable dead-time, so that the two switches of a half bridge are never on together.

A per-pin polarity bit is applied as the very last stage before the pin. While the counter is stopped, the pins rest at an idle level, and that idle level is set by the same polarity bits. Both pin levels come from flip-flops, so they change only on a clock edge and never glitch.

Top module: `cpwm_pair_out`

## Requirements
- R1: While `rst_n` is low, both `out_even` and `out_odd` are 0.
- R2: At each clock edge where `run` is 0, `out_even` takes the value of `inv_even` and `out_odd` takes the value of `inv_odd`. This is the idle level: 1 when the pin is inverted and 0 when it is not.
- R3: In complementary mode (`comp_mode` = 1), the even pin is sourced from `pwm_raw` and the odd pin from the inverse of `pwm_raw`. In independent mode (`comp_mode` = 0), both pins are sourced from `pwm_raw`.
- R4: In independent mode with `run` = 1, each pin becomes (`pwm_raw` ^ its invert bit) at the next edge, for any value of `dead_cnt`.
- R5: In complementary mode, when a pin's source is sampled high at D+1 consecutive edges while running (D = `dead_cnt`), that pin becomes active at the last of those edges. With D = 0, it becomes active at the first edge where its source is high.
- R6: At any edge where a pin's source is low, or `run` is 0, that pin becomes inactive at that edge, with no delay.
- R7: In complementary mode, a source pulse that lasts D edges or fewer never makes its pin active.
- R8: Polarity is applied last. The pin level equals its active state XOR its invert bit, so an inverted pin is 0 when active.
- R9: In complementary mode, the two pins are never active at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_raw | input | 1 | Raw PWM waveform from the channel counter |
| run | input | 1 | Counter running flag; 0 selects the idle level |
| comp_mode | input | 1 | 1 = complementary mode, 0 = independent mode |
| dead_cnt | input | DT_W | Dead-time in PWM clock cycles |
| inv_even | input | 1 | Polarity invert for the even pin |
| inv_odd | input | 1 | Polarity invert for the odd pin |
| out_even | output | 1 | Even pin level |
| out_odd | output | 1 | Odd pin level |

## Verification
The assertions check five things on every cycle: the idle level while stopped, immediate turn-off, pass-through in independent mode, zero-delay behaviour at dead-time zero, and that the two pins are never active together in complementary mode. The exact turn-on cycle after D+1 high samples, and the swallowing of pulses no longer than the dead-time, depend on the history of the input. Only the bench's reference model shows those, together with the directed pulse-length cases.

// File: rtl/cpwm_pair_out.sv
module cpwm_pair_out #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwm_raw,
  input  logic            run,
  input  logic            comp_mode,
  input  logic [DT_W-1:0] dead_cnt,
  input  logic            inv_even,
  input  logic            inv_odd,
  output logic            out_even,
  output logic            out_odd
);
  localparam int NCH = 2;

  logic [NCH-1:0] src, inv, pin;

  assign src = {comp_mode ? ~pwm_raw : pwm_raw, pwm_raw};
  assign inv = {inv_odd, inv_even};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [DT_W-1:0] cnt_q, cnt_d;
    logic            on_q, on_d, pin_q;

    always_comb begin
      on_d  = 1'b0;
      cnt_d = '0;
      if (run && src[i]) begin
        if (!comp_mode || on_q || cnt_q >= dead_cnt) on_d = 1'b1;
        else cnt_d = cnt_q + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
        on_q  <= 1'b0;
        pin_q <= 1'b0;
      end else begin
        cnt_q <= cnt_d;
        on_q  <= on_d;
        pin_q <= on_d ^ inv[i];
      end
    end

    assign pin[i] = pin_q;
  end

  assign out_even = pin[0];
  assign out_odd  = pin[1];
endmodule

module cpwm_pair_out_chk #(
  parameter int DT_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pwm_raw,
  input logic            run,
  input logic            comp_mode,
  input logic [DT_W-1:0] dead_cnt,
  input logic            inv_even,
  input logic            inv_odd,
  input logic            out_even,
  input logic            out_odd
);
  p_reset_low_r1: assert property (@(posedge clk)
    !rst_n |-> (!out_even && !out_odd));

  p_idle_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (out_even == $past(inv_even) && out_odd == $past(inv_odd)));

  p_indep_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !comp_mode) |=> (out_even == ($past(pwm_raw) ^ $past(inv_even)) &&
                             out_odd  == ($past(pwm_raw) ^ $past(inv_odd))));

  p_zero_dead_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && comp_mode && dead_cnt == '0) |=>
      (out_even == ($past(pwm_raw) ^ $past(inv_even)) &&
       out_odd  == (!$past(pwm_raw) ^ $past(inv_odd))));

  p_off_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_raw |=> (out_even == $past(inv_even)));

  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    comp_mode |=> !((out_even ^ $past(inv_even)) && (out_odd ^ $past(inv_odd))));
endmodule

bind cpwm_pair_out cpwm_pair_out_chk #(.DT_W(DT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_raw(pwm_raw), .run(run), .comp_mode(comp_mode),
  .dead_cnt(dead_cnt), .inv_even(inv_even), .inv_odd(inv_odd),
  .out_even(out_even), .out_odd(out_odd)
);

// File: tb/tb_cpwm_pair_out.sv
module tb_cpwm_pair_out;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pwm_raw = 1'b0, run = 1'b0, comp_mode = 1'b0, inv_even = 1'b0, inv_odd = 1'b0;
  logic [7:0] dead_cnt = 8'd0;
  logic out_even, out_odd;
  int n_chk = 0, n_bad = 0;
  int h_e = 0, h_o = 0;
  bit on_e = 0, on_o = 0;

  always #5 clk = ~clk;

  cpwm_pair_out #(.DT_W(8)) dut (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void upd(input bit s, inout int h, inout bit on);
    if (!run || !s) begin h = 0; on = 0; end
    else begin
      h++;
      if (!comp_mode || on || h > int'(dead_cnt)) on = 1;
    end
  endfunction

  task automatic step(input logic raw, input logic r, input string tag);
    pwm_raw = raw; run = r;
    upd(raw, h_e, on_e);
    upd(comp_mode ? !raw : raw, h_o, on_o);
    @(posedge clk); #1;
    chk({tag, " even"}, out_even, on_e ^ inv_even);
    chk({tag, " odd"}, out_odd, on_o ^ inv_odd);
    if (comp_mode) chk("R9 overlap", (out_even ^ inv_even) & (out_odd ^ inv_odd), 1'b0);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1badcafe));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset even", out_even, 1'b0);
    chk("R1 reset odd", out_odd, 1'b0);
    rst_n = 1'b1;

    for (int k = 0; k < 4; k++) begin
      inv_even = k[0]; inv_odd = k[1];
      step(1'b1, 1'b0, "R2 idle");
    end

    comp_mode = 0; dead_cnt = 8'd9; inv_even = 0; inv_odd = 1;
    step(1'b1, 1'b1, "R4 indep");
    chk("R4 no dead-time even", out_even, 1'b1);
    chk("R8 inverted odd", out_odd, 1'b0);
    step(1'b0, 1'b1, "R4 indep off");

    comp_mode = 1; dead_cnt = 0; inv_even = 0; inv_odd = 0;
    step(1'b1, 1'b0, "R2 idle");
    step(1'b1, 1'b1, "R3 R5 zero dead");
    chk("R3 odd is complement", out_odd, 1'b0);
    step(1'b0, 1'b1, "R3 R6 zero dead");
    chk("R3 odd on", out_odd, 1'b1);

    dead_cnt = 3;
    step(1'b0, 1'b0, "R2 idle");
    for (int k = 0; k < 3; k++) begin
      step(1'b1, 1'b1, "R5 wait");
      chk("R5 still off", out_even, 1'b0);
    end
    step(1'b1, 1'b1, "R5 turn-on");
    chk("R5 on after D+1", out_even, 1'b1);
    step(1'b0, 1'b1, "R6 off");
    chk("R6 immediate off", out_even, 1'b0);
    for (int k = 0; k < 3; k++) begin
      step(1'b1, 1'b1, "R7 short");
      chk("R7 short pulse swallowed", out_even, 1'b0);
    end
    step(1'b0, 1'b1, "R7 end");
    chk("R7 odd delayed", out_odd, 1'b0);

    for (int seg = 0; seg < 150; seg++) begin
      comp_mode = 1'($urandom_range(0, 1));
      dead_cnt  = 8'($urandom_range(0, 6));
      inv_even  = 1'($urandom_range(0, 1));
      inv_odd   = 1'($urandom_range(0, 1));
      step(1'($urandom_range(0, 1)), 1'b0, "R2 idle");
      for (int c = 0; c < 40; c++) begin
        logic r;
        r = ($urandom_range(0, 3) == 0) ? pwm_raw ^ 1'b1 : pwm_raw;
        step(r, ($urandom_range(0, 30) != 0), "R3 R5 R6 R8 random");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule